// File: doc/BRIEF.md
# Receive Endpoint Two-Slot Buffer Controller

This block keeps the status of one OUT endpoint whose packet memory can hold one or two whole packets. The bus side reports each received packet with a single commit strobe and its byte count. The CPU side reports packet removal in one of two ways: it clears the ready flag explicitly, or it signals that it has finished reading a packet and auto-clear takes effect. The block drives a receive-ready flag, a buffer-full flag, a one-cycle endpoint interrupt, a not-ready signal that tells the bus side to answer further OUT data with NAK, and the byte count of the oldest pending packet.

Two-packet (ping-pong) operation needs two conditions. The memory size parameter must be at least twice the maximum packet size, and a per-endpoint disable bit must be cleared by software. That bit resets to 1, so the endpoint starts in one-packet mode. The control is a four-state machine:
- EMPTY: no packet is pending.
- ONE: one packet is pending, and ready is high.
- TWO: two packets are pending, and both ready and full are high.
- RELOAD: a one-cycle gap that follows a clear while full was high. Ready and full are both low in this state.

The transitions are:
- EMPTY→ONE on an accepted commit.
- ONE→TWO on an accepted commit in two-packet mode.
- ONE→EMPTY on a clear.
- ONE→RELOAD on a clear together with an accepted commit.
- TWO→RELOAD on a clear.
- RELOAD→ONE unconditionally.
- Any state→EMPTY on flush.

Top module: `ep_rx_buf_ctrl`

## Requirements
- R1: After reset, ready, full, interrupt and not-ready are 0, and the double-buffer disable bit reads 1. A write with `dbl_dis_we` loads `dbl_dis_d` into that bit on the next edge.
- R2: A commit accepted while no packet is pending sets ready on the next edge. It raises `rx_irq` for exactly one cycle, leaves full at 0, and presents the committed length on `head_len`.
- R3: In one-packet mode, not-ready is high while ready is high, and a commit in that state is ignored. After a clear, ready and not-ready fall, and a new commit is accepted.
- R4: In two-packet mode, a second commit while one packet is pending sets full. It raises no interrupt, keeps ready high and sets not-ready. A third commit is ignored.
- R5: A clear while full is high drops both ready and full on the next edge (RELOAD). One cycle later, ready rises again together with a one-cycle interrupt.
- R6: With `autoclr_en`=1, an unload strobe removes the pending packet exactly as a clear would, but only when its length equals MAX_PKT. With any shorter length, the unload has no effect.
- R7: With `autoclr_en`=0, an unload strobe has no effect, even for a packet of length MAX_PKT.
- R8: `head_len` always shows the length of the oldest pending packet, including after the older of two packets has been removed.
- R9: Flush empties both slots in one cycle. Ready, full and not-ready go to 0, and flush takes priority over a commit or clear in the same cycle. The next commit then appears on `head_len`.
- R10: When FIFO_BYTES < 2*MAX_PKT, the endpoint stays in one-packet mode even with the disable bit cleared. Full never rises, and a second commit is ignored.
- R11: In two-packet mode, a clear and a commit in the same cycle in ONE go to RELOAD. The new packet is then presented with ready and an interrupt one cycle later.
- R12: Not-ready is high during RELOAD, and a commit in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous empty of both slots |
| pkt_commit | input | 1 | One packet fully received |
| pkt_len | input | LEN_W (7) | Byte count of the committed packet |
| cpu_unload | input | 1 | CPU finished reading the oldest packet |
| cpu_clr_ready | input | 1 | CPU clears the ready flag |
| autoclr_en | input | 1 | Enables auto-clear on max-size unload |
| dbl_dis_we | input | 1 | Write strobe for the disable bit |
| dbl_dis_d | input | 1 | Value written to the disable bit |
| dbl_dis | output | 1 | Current double-buffer disable bit |
| rx_ready | output | 1 | A packet is ready to unload |
| rx_full | output | 1 | Two packets are pending |
| rx_irq | output | 1 | One-cycle endpoint interrupt |
| nak | output | 1 | No slot free; answer OUT data with NAK |
| head_len | output | LEN_W (7) | Length of the oldest pending packet |

## Verification
The RELOAD state is the hardest case to reach: it lasts one cycle and only follows a clear while two packets are queued, or a clear that coincides with a commit. The bench sweeps every packet length from 0 to MAX_PKT as the first of a pair. It queues the complementary length behind it, clears, and samples the gap cycle and the re-raise cycle separately. Dedicated sequences then commit during the gap and issue clear and commit together. A second instance, too small for two packets, receives the same stimulus to show that it stays in one-packet mode.

// File: rtl/ep_rx_pkg.sv
package ep_rx_pkg;
    typedef enum logic [1:0] {
        ST_EMPTY  = 2'd0,
        ST_ONE    = 2'd1,
        ST_TWO    = 2'd2,
        ST_RELOAD = 2'd3
    } rxq_state_e;
endpackage

// File: rtl/ep_rx_slots.sv
// Length storage for the queued packets, written in arrival order.
module ep_rx_slots #(
    parameter int LEN_W = 7,
    parameter int NSLOT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic             pop,
    input  logic [LEN_W-1:0] wr_len,
    output logic [LEN_W-1:0] head_len
);
    localparam int PW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

    logic [PW-1:0]    wr_ptr, rd_ptr;
    logic [LEN_W-1:0] slot_q [NSLOT];

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(NSLOT - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= nxt(wr_ptr);
            if (pop)  rd_ptr <= nxt(rd_ptr);
        end
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot_q[g] <= '0;
            else if (push && !clr && wr_ptr == PW'(g))
                slot_q[g] <= wr_len;
        end
    end

    assign head_len = slot_q[rd_ptr];
endmodule

// File: rtl/ep_rx_fsm.sv
// Occupancy state machine: flags, NAK, interrupt and slot strobes.
module ep_rx_fsm
    import ep_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       commit,
    input  logic       pop_req,
    input  logic       dbl_ok,
    output logic       push,
    output logic       pop,
    output logic       rdy,
    output logic       full,
    output logic       nak,
    output logic       irq
);
    rxq_state_e state_q, state_d;
    logic       accept;
    logic       irq_d;

    // NAK decision depends only on the current state and mode.
    always_comb begin
        unique case (state_q)
            ST_EMPTY:  nak = 1'b0;
            ST_ONE:    nak = !dbl_ok;
            ST_TWO:    nak = 1'b1;
            ST_RELOAD: nak = 1'b1;
            default:   nak = 1'b1;
        endcase
    end

    assign accept = commit && !nak && !flush;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        irq_d   = 1'b0;
        pop     = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                if (accept) begin
                    state_d = ST_ONE;
                    irq_d   = 1'b1;
                end
            end
            ST_ONE: begin
                if (pop_req) begin
                    pop     = 1'b1;
                    state_d = accept ? ST_RELOAD : ST_EMPTY;
                end else if (accept) begin
                    state_d = ST_TWO;
                end
            end
            ST_TWO: begin
                if (pop_req) begin
                    pop     = 1'b1;
                    state_d = ST_RELOAD;
                end
            end
            ST_RELOAD: begin
                state_d = ST_ONE;
                irq_d   = 1'b1;
            end
            default: state_d = ST_EMPTY;
        endcase
        if (flush) begin
            state_d = ST_EMPTY;
            irq_d   = 1'b0;
            pop     = 1'b0;
        end
    end

    assign push = accept;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            irq     <= 1'b0;
        end else begin
            state_q <= state_d;
            irq     <= irq_d;
        end
    end

    // Flag outputs.
    always_comb begin
        unique case (state_q)
            ST_EMPTY:  begin rdy = 1'b0; full = 1'b0; end
            ST_ONE:    begin rdy = 1'b1; full = 1'b0; end
            ST_TWO:    begin rdy = 1'b1; full = 1'b1; end
            ST_RELOAD: begin rdy = 1'b0; full = 1'b0; end
            default:   begin rdy = 1'b0; full = 1'b0; end
        endcase
    end
endmodule

// File: rtl/ep_rx_buf_ctrl.sv
module ep_rx_buf_ctrl #(
    parameter int MAX_PKT    = 64,
    parameter int FIFO_BYTES = 128,
    parameter int LEN_W      = $clog2(MAX_PKT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             pkt_commit,
    input  logic [LEN_W-1:0] pkt_len,
    input  logic             cpu_unload,
    input  logic             cpu_clr_ready,
    input  logic             autoclr_en,
    input  logic             dbl_dis_we,
    input  logic             dbl_dis_d,
    output logic             dbl_dis,
    output logic             rx_ready,
    output logic             rx_full,
    output logic             rx_irq,
    output logic             nak,
    output logic [LEN_W-1:0] head_len
);
    localparam bit DBL_CAPABLE = (FIFO_BYTES >= 2 * MAX_PKT);
    localparam int NSLOT       = DBL_CAPABLE ? 2 : 1;

    logic dbl_dis_q;
    logic dbl_ok;
    logic auto_hit;
    logic pop_req;
    logic push, pop;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          dbl_dis_q <= 1'b1;
        else if (dbl_dis_we) dbl_dis_q <= dbl_dis_d;
    end

    assign dbl_dis  = dbl_dis_q;
    assign dbl_ok   = DBL_CAPABLE && !dbl_dis_q;
    assign auto_hit = cpu_unload && autoclr_en && (head_len == LEN_W'(MAX_PKT));
    assign pop_req  = cpu_clr_ready || auto_hit;

    ep_rx_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .commit  (pkt_commit),
        .pop_req (pop_req),
        .dbl_ok  (dbl_ok),
        .push    (push),
        .pop     (pop),
        .rdy     (rx_ready),
        .full    (rx_full),
        .nak     (nak),
        .irq     (rx_irq)
    );

    ep_rx_slots #(
        .LEN_W (LEN_W),
        .NSLOT (NSLOT)
    ) u_slots (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (flush),
        .push     (push),
        .pop      (pop),
        .wr_len   (pkt_len),
        .head_len (head_len)
    );
endmodule

// File: rtl/ep_rx_buf_chk.sv
module ep_rx_buf_chk (
    input logic clk,
    input logic rst_n,
    input logic flush,
    input logic cpu_clr_ready,
    input logic dbl_dis,
    input logic rx_ready,
    input logic rx_full,
    input logic rx_irq,
    input logic nak
);
    // R2: interrupt lasts one cycle
    a_r2_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rx_irq |=> !rx_irq);
    // R2: each rise of ready comes with the interrupt
    a_r2_rise_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> rx_irq);
    // R4: full only while ready, and then no slot is free
    a_r4_full_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full |-> (rx_ready && nak));
    // R3: one-packet mode refuses data while ready
    a_r3_single_nak: assert property (@(posedge clk) disable iff (!rst_n)
        (dbl_dis && rx_ready) |-> nak);
    // R5: clear with full opens a gap
    a_r5_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full && cpu_clr_ready && !flush) |=> (!rx_ready && !rx_full));
    // R5: gap is followed by ready and interrupt
    a_r5_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && $past(rx_full) && !$past(flush) && !flush) |=> (rx_ready && rx_irq));
    // R9: flush empties the endpoint
    a_r9_flush: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!rx_ready && !rx_full && !nak));
endmodule

bind ep_rx_buf_ctrl ep_rx_buf_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (flush),
    .cpu_clr_ready (cpu_clr_ready),
    .dbl_dis       (dbl_dis),
    .rx_ready      (rx_ready),
    .rx_full       (rx_full),
    .rx_irq        (rx_irq),
    .nak           (nak)
);

// File: tb/ep_rx_buf_ctrl_bench.sv
`timescale 1ns/1ps
module ep_rx_buf_ctrl_bench;
    localparam int MAXP = 64;
    localparam int LW   = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 0, pkt_commit = 0, cpu_unload = 0, cpu_clr_ready = 0;
    logic autoclr_en = 0, dbl_dis_we = 0, dbl_dis_d = 0;
    logic [LW-1:0] pkt_len = '0;

    logic dbl_dis, rx_ready, rx_full, rx_irq, nak;
    logic [LW-1:0] head_len;
    logic s_dis, s_ready, s_full, s_irq, s_nak;
    logic [LW-1:0] s_head;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ep_rx_buf_ctrl #(.MAX_PKT(MAXP), .FIFO_BYTES(128)) u_ep_rx_buf_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pkt_commit(pkt_commit),
        .pkt_len(pkt_len), .cpu_unload(cpu_unload), .cpu_clr_ready(cpu_clr_ready),
        .autoclr_en(autoclr_en), .dbl_dis_we(dbl_dis_we), .dbl_dis_d(dbl_dis_d),
        .dbl_dis(dbl_dis), .rx_ready(rx_ready), .rx_full(rx_full),
        .rx_irq(rx_irq), .nak(nak), .head_len(head_len));

    ep_rx_buf_ctrl #(.MAX_PKT(MAXP), .FIFO_BYTES(64)) u_ep_rx_buf_ctrl_small (
        .clk(clk), .rst_n(rst_n), .flush(flush), .pkt_commit(pkt_commit),
        .pkt_len(pkt_len), .cpu_unload(cpu_unload), .cpu_clr_ready(cpu_clr_ready),
        .autoclr_en(autoclr_en), .dbl_dis_we(dbl_dis_we), .dbl_dis_d(dbl_dis_d),
        .dbl_dis(s_dis), .rx_ready(s_ready), .rx_full(s_full),
        .rx_irq(s_irq), .nak(s_nak), .head_len(s_head));

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FIFO check FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // One clock edge, then sample 1 ns later and drop all strobes.
    task automatic cyc();
        @(posedge clk);
        #1;
        pkt_commit = 0; cpu_unload = 0; cpu_clr_ready = 0;
        flush = 0; dbl_dis_we = 0;
    endtask

    task automatic commit(input int len);
        pkt_commit = 1; pkt_len = LW'(len);
        cyc();
    endtask

    task automatic clear();
        cpu_clr_ready = 1;
        cyc();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cyc();
        // R1 reset state
        check("R1 ready", rx_ready, 0);
        check("R1 full", rx_full, 0);
        check("R1 irq", rx_irq, 0);
        check("R1 nak", nak, 0);
        check("R1 disable bit", dbl_dis, 1);

        // R2 / R3 one-packet mode
        commit(10);
        check("R2 ready", rx_ready, 1);
        check("R2 irq", rx_irq, 1);
        check("R2 full", rx_full, 0);
        check("R2 head", head_len, 10);
        check("R3 nak while ready", nak, 1);
        cyc();
        check("R2 irq one cycle", rx_irq, 0);
        commit(20);
        check("R3 second ignored full", rx_full, 0);
        check("R3 second ignored head", head_len, 10);
        clear();
        check("R3 clear ready", rx_ready, 0);
        check("R3 clear nak", nak, 0);
        commit(33);
        check("R3 accepted after clear", head_len, 33);
        clear();

        // R1 write disable bit
        dbl_dis_we = 1; dbl_dis_d = 0;
        cyc();
        check("R1 disable write", dbl_dis, 0);
        check("R10 small disable write", s_dis, 0);

        // R4 third commit ignored
        commit(1);
        commit(2);
        commit(3);
        check("R4 third ignored full", rx_full, 1);
        check("R4 third ignored head", head_len, 1);
        clear();
        cyc();
        check("R8 head after pop", head_len, 2);
        clear();
        check("R4 empty after two clears", rx_ready, 0);

        // R4 / R5 / R8 / R10 sweep of length pairs
        for (int l = 0; l <= MAXP; l++) begin
            commit(l);
            check("R2 sweep irq", rx_irq, 1);
            check("R10 small nak after one", s_nak, 1);
            commit(MAXP - l);
            check("R4 full", rx_full, 1);
            check("R4 no irq", rx_irq, 0);
            check("R4 nak", nak, 1);
            check("R8 oldest head", head_len, l);
            check("R10 small never full", s_full, 0);
            check("R10 small head", s_head, l);
            clear();
            check("R5 gap ready", rx_ready, 0);
            check("R5 gap full", rx_full, 0);
            check("R12 gap nak", nak, 1);
            cyc();
            check("R5 re-raise ready", rx_ready, 1);
            check("R5 re-raise irq", rx_irq, 1);
            check("R8 second head", head_len, MAXP - l);
            clear();
            check("R5 drained", rx_ready, 0);
        end

        // R11 clear and commit together
        commit(5);
        pkt_commit = 1; pkt_len = 7; cpu_clr_ready = 1;
        cyc();
        check("R11 gap ready", rx_ready, 0);
        check("R11 gap full", rx_full, 0);
        cyc();
        check("R11 ready", rx_ready, 1);
        check("R11 irq", rx_irq, 1);
        check("R11 head", head_len, 7);
        clear();

        // R12 commit during gap ignored
        commit(3);
        commit(4);
        clear();
        check("R12 nak in gap", nak, 1);
        commit(9);
        check("R12 full after gap", rx_full, 0);
        check("R12 head after gap", head_len, 4);
        clear();
        check("R12 gap commit dropped", rx_ready, 0);
        check("R12 empty nak", nak, 0);

        // R6 / R7 auto-clear sweep
        for (int ae = 0; ae < 2; ae++) begin
            for (int l = MAXP - 3; l <= MAXP; l++) begin
                commit(l);
                autoclr_en = ae[0]; cpu_unload = 1;
                cyc();
                if (ae == 1) check("R6 auto-clear", rx_ready, (l == MAXP) ? 0 : 1);
                else         check("R7 auto-clear off", rx_ready, 1);
                if (rx_ready) clear();
            end
        end
        // R6 auto-clear with two queued goes through the gap
        autoclr_en = 1;
        commit(MAXP);
        commit(8);
        cpu_unload = 1;
        cyc();
        check("R6 auto gap", rx_ready, 0);
        cyc();
        check("R6 auto re-raise", rx_ready, 1);
        check("R6 auto head", head_len, 8);
        cpu_unload = 1;
        cyc();
        check("R6 short unload kept", rx_ready, 1);
        clear();
        autoclr_en = 0;

        // R9 flush beats commit
        commit(1);
        commit(2);
        flush = 1; pkt_commit = 1; pkt_len = 50;
        cyc();
        check("R9 ready", rx_ready, 0);
        check("R9 full", rx_full, 0);
        check("R9 nak", nak, 0);
        check("R9 irq", rx_irq, 0);
        commit(30);
        check("R9 head after flush", head_len, 30);
        check("R9 ready after flush", rx_ready, 1);
        clear();

        finish_run();
    end
endmodule